// File: doc/BRIEF.md
# Vectored Level-Interrupt Controller

This block gathers 96 level-sensitive interrupt lines and presents them to a processor through a small word-addressed register port with a single-cycle write and a combinational read. The lines are grouped in three banks of 32. Each bank has a capture register, an enable register and a blocking register. A read-only register returns the winning line number already scaled to a word offset. A service routine reads that one register, dispatches the line it names, clears the capture bit and reads again until it sees zero.

Two further registers hold a protection flag and the setting for an external non-maskable input. That input drives the fast request output, which is separate from the normal interrupt request. The fast-request state can also be seen through a read-only bank.

Top module: `lvl_vic`

## Requirements
- R1: After reset, all capture, enable and blocking bits are 0, the protection flag and the non-maskable setting are 0, `irq_o` and `fiq_o` are low, and every register reads 0.
- R2: The register offsets are fixed as follows. The vector is at 0x00, protection at 0x08 and non-maskable control at 0x0C. Capture bank b is at 0x10+4b, fast-capture bank b at 0x20+4b, enable bank b at 0x40+4b and blocking bank b at 0x50+4b, for b = 0, 1, 2.
- R3: Line n is held in bank n/32 at bit n%32. While a line is high at a clock edge, its capture bit is 1 after that edge, even if the same edge carries a clear for it.
- R4: A write to a capture register clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing 0xFFFFFFFF clears the whole bank for lines that are low.
- R5: An enable bit of 0 keeps its line out of `irq_o` and the vector, and enable bits reset to 0. A line counts as active when it is captured, enabled and not blocked.
- R6: A blocking bit of 1 keeps its line out of `irq_o` and the vector, while the capture bit still shows the line.
- R7: `irq_o` is high exactly when at least one line is active. It is derived from registered state with no extra delay.
- R8: The vector register reads (lowest-numbered active line) × 4 and reads 0 when no line is active. Bits [1:0] are always 0, and line 0 is indistinguishable from "none".
- R9: The protection register stores bit 0 and reads other bits as 0. Non-maskable control stores bits [1:0]. Both read back the last written value.
- R10: `fiq_o` is a register loaded each cycle with `nmi_i` XOR control bit 0, so bit 0 = 1 selects active-low. Fast-capture bank 0 bit 0 reads `fiq_o`, and every other fast-capture bit reads 0.
- R11: Unmapped or misaligned offsets read 0 and ignore writes. Writes to the vector and the fast-capture banks change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 96 | Level interrupt lines |
| nmi_i | input | 1 | External non-maskable line |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from offset |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast request |

## Verification
The source lines, the non-maskable input and register writes take effect at the first rising edge after they are driven. After that edge, `irq_o`, `fiq_o` and the read data of any offset are already final, because reads are combinational from registered state. The bench drives all inputs on the falling edge. It sets the read offset 1 ns after the rising edge and compares half a nanosecond later, against a model that it updates once per rising edge with the same one-edge latency.

// File: rtl/lvl_vic.sv
module lvl_vic #(
  parameter int NBANK = 3,
  parameter int BW    = 32,
  parameter int AW    = 8,
  parameter int NMI_W = 2,
  localparam int NSRC = NBANK * BW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            nmi_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [BW-1:0]   bus_wdata_i,
  output logic [BW-1:0]   bus_rdata_o,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int IW = $clog2(NSRC);
  localparam logic [AW-1:0] A_VEC  = AW'(8'h00);
  localparam logic [AW-1:0] A_PROT = AW'(8'h08);
  localparam logic [AW-1:0] A_NMI  = AW'(8'h0C);
  localparam int B_CAP = 'h10;
  localparam int B_FST = 'h20;
  localparam int B_ENA = 'h40;
  localparam int B_BLK = 'h50;

  logic [NSRC-1:0]  cap_q, ena_q, blk_q, clr, active;
  logic             prot_q, fiq_q;
  logic [NMI_W-1:0] nmic_q;
  logic [IW-1:0]    win;
  logic             any;
  logic [NBANK-1:0] hit_cap, hit_fst, hit_ena, hit_blk;

  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    assign hit_cap[b] = bus_addr_i == AW'(B_CAP + 4*b);
    assign hit_fst[b] = bus_addr_i == AW'(B_FST + 4*b);
    assign hit_ena[b] = bus_addr_i == AW'(B_ENA + 4*b);
    assign hit_blk[b] = bus_addr_i == AW'(B_BLK + 4*b);
    assign clr[b*BW +: BW] = (bus_wr_i && hit_cap[b]) ? bus_wdata_i : '0;
  end

  assign active = cap_q & ena_q & ~blk_q;
  assign any    = |active;
  assign irq_o  = any;
  assign fiq_o  = fiq_q;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (active[i]) win = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      ena_q  <= '0;
      blk_q  <= '0;
      prot_q <= 1'b0;
      nmic_q <= '0;
      fiq_q  <= 1'b0;
    end else begin
      cap_q <= (cap_q & ~clr) | src_i;
      fiq_q <= nmi_i ^ nmic_q[0];
      if (bus_wr_i) begin
        for (int b = 0; b < NBANK; b++) begin
          if (hit_ena[b]) ena_q[b*BW +: BW] <= bus_wdata_i;
          if (hit_blk[b]) blk_q[b*BW +: BW] <= bus_wdata_i;
        end
        if (bus_addr_i == A_PROT) prot_q <= bus_wdata_i[0];
        if (bus_addr_i == A_NMI)  nmic_q <= bus_wdata_i[NMI_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_VEC)  bus_rdata_o = any ? BW'({win, 2'b00}) : '0;
    if (bus_addr_i == A_PROT) bus_rdata_o = BW'(prot_q);
    if (bus_addr_i == A_NMI)  bus_rdata_o = BW'(nmic_q);
    for (int b = 0; b < NBANK; b++) begin
      if (hit_cap[b]) bus_rdata_o = cap_q[b*BW +: BW];
      if (hit_ena[b]) bus_rdata_o = ena_q[b*BW +: BW];
      if (hit_blk[b]) bus_rdata_o = blk_q[b*BW +: BW];
      if (hit_fst[b] && b == 0) bus_rdata_o = BW'(fiq_q);
    end
  end

  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cap_q & $past(src_i)) == $past(src_i)));

  // R4
  w1c_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == AW'(B_CAP)) |=>
      ((cap_q[BW-1:0] & $past(bus_wdata_i) & ~$past(src_i[BW-1:0])) == '0));

  // R5
  no_enable_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0) |-> !irq_o);

  // R6
  all_blocked_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q == '1) |-> !irq_o);

  // R8
  vec_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == A_VEC && irq_o && !active[0]) |-> (bus_rdata_o != '0 && bus_rdata_o[1:0] == 2'b00));

  // R10
  fiq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fiq_o == ($past(nmi_i) ^ $past(nmic_q[0]))));
endmodule

// File: tb/lvl_vic_tb.sv
`timescale 1ns/100ps
module lvl_vic_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [95:0] src = '0;
  logic        nmi = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, fiq;

  lvl_vic dut_i (.clk(clk), .rst_n(rst_n), .src_i(src), .nmi_i(nmi),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq));

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [95:0] cap_m = '0, ena_m = '0, blk_m = '0;
  logic        prot_m = 0, fiq_m = 0;
  logic [1:0]  nmic_m = '0;

  function automatic logic [95:0] act_m();
    return cap_m & ena_m & ~blk_m;
  endfunction

  function automatic logic [31:0] vec_m();
    logic [95:0] a = act_m();
    for (int i = 0; i < 96; i++) if (a[i]) return 32'(i) << 2;
    return 32'd0;
  endfunction

  function automatic logic [31:0] rd_m(logic [7:0] a);
    if (a == 8'h00) return vec_m();
    if (a == 8'h08) return {31'd0, prot_m};
    if (a == 8'h0C) return {30'd0, nmic_m};
    if (a == 8'h20) return {31'd0, fiq_m};
    for (int b = 0; b < 3; b++) begin
      if (a == 8'(8'h10 + 4*b)) return cap_m[b*32 +: 32];
      if (a == 8'(8'h40 + 4*b)) return ena_m[b*32 +: 32];
      if (a == 8'(8'h50 + 4*b)) return blk_m[b*32 +: 32];
    end
    return 32'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(logic [95:0] s, logic n, logic w, logic [7:0] a, logic [31:0] d);
    logic [95:0] clr = '0;
    @(negedge clk);
    src = s; nmi = n; wr = w; addr = a; wdata = d;
    @(posedge clk);
    fiq_m = n ^ nmic_m[0];
    if (w) begin
      for (int b = 0; b < 3; b++) begin
        if (a == 8'(8'h10 + 4*b)) clr[b*32 +: 32] = d;
        if (a == 8'(8'h40 + 4*b)) ena_m[b*32 +: 32] = d;
        if (a == 8'(8'h50 + 4*b)) blk_m[b*32 +: 32] = d;
      end
      if (a == 8'h08) prot_m = d[0];
      if (a == 8'h0C) nmic_m = d[1:0];
    end
    cap_m = (cap_m & ~clr) | s;
    #1 wr = 1'b0;
  endtask

  task automatic look(string tag, logic [7:0] a);
    addr = a;
    #0.5;
    chk(tag, rdata, rd_m(a));
    chk({tag, " irq R7"}, {31'd0, irq}, {31'd0, |act_m()});
    chk({tag, " fiq R10"}, {31'd0, fiq}, {31'd0, fiq_m});
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  localparam logic [7:0] ADDRS [16] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20,
                                        8'h24, 8'h30, 8'h40, 8'h44, 8'h48, 8'h50, 8'h54, 8'h58};
  initial begin
    logic [95:0] s;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #0.5;
    foreach (ADDRS[k]) begin addr = ADDRS[k]; #0.1; chk("R1 reset read", rdata, 32'd0); end
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 fiq", {31'd0, fiq}, 32'd0);

    s = '0; s[40] = 1'b1;
    step(s, 0, 0, 8'h00, 0);           look("R5 disabled vec", 8'h00);
    look("R3 bank1 bit8", 8'h14);
    step(s, 0, 1, 8'h44, 32'h100);     look("R8 vec 160", 8'h00);
    chk("R8 vec value", rdata, 32'd160);
    s[5] = 1'b1;
    step(s, 0, 1, 8'h40, 32'h20);      look("R8 lowest wins", 8'h00);
    chk("R8 vec 20", rdata, 32'd20);
    step(s, 0, 1, 8'h50, 32'h20);      look("R6 blocked vec", 8'h00);
    look("R6 capture visible", 8'h10);
    s = '0;
    step(s, 0, 1, 8'h14, 32'h0000_00ff); look("R4 zero bits kept", 8'h14);
    step(s, 0, 1, 8'h14, 32'hffff_ffff); look("R4 clear all", 8'h14);
    look("R8 none vec", 8'h00);
    s[5] = 1'b1;
    step(s, 0, 1, 8'h10, 32'hffff_ffff); look("R3 clear while high", 8'h10);
    step(s, 0, 1, 8'h00, 32'hffff_ffff); look("R11 vec write ignored", 8'h00);
    step(s, 0, 1, 8'h20, 32'hffff_ffff); look("R11 fast write ignored", 8'h20);
    step(s, 0, 1, 8'h30, 32'hffff_ffff); look("R11 unmapped read", 8'h30);
    step(s, 0, 1, 8'h41, 32'hffff_ffff); look("R11 misaligned", 8'h40);
    step(s, 0, 1, 8'h08, 32'hffff_ffff); look("R9 prot", 8'h08);
    step(s, 1, 1, 8'h0C, 32'h3);         look("R10 nmi high", 8'h20);
    step(s, 1, 0, 8'h00, 0);             look("R10 low polarity", 8'h0C);
    step(s, 0, 1, 8'h40, 32'h1);         look("R8 line0 reads zero", 8'h00);

    for (int it = 0; it < 4000; it++) begin
      logic [7:0]  wa = ADDRS[$urandom_range(15)];
      logic [31:0] wd = $urandom;
      for (int b = 0; b < 3; b++)
        s[b*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
      if ($urandom_range(7) == 0) wd = 32'hffff_ffff;
      step(s, 1'($urandom), 1'($urandom), wa, wd);
      look("R2 random read", ADDRS[$urandom_range(15)]);
      addr = 8'h00; #0.1;
      chk("R8 random vec", rdata, vec_m());
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule